// File: doc/BRIEF.md
# Bus-Fed Scan Test Buffer Wrapper

This block wraps one core for scan testing over an ordinary on-chip data bus. A bus master writes a packet of test stimulus, one bus word per transfer, into an input buffer. Once the configured number of words is present, the controller enters a separate application stage. In that stage the buffered packet is cut into slices of one bit per scan chain, and the slices are shifted into the wrapper scan chains at a divided scan rate. The bits leaving the far end of each chain during the same shifts are collected in an output buffer. The master then reads that buffer back word by word. Only after the last response word has been read does the wrapper take the next packet.

Each wrapper chain is made of a group of input boundary cells, the core's own internal chain, and a group of output boundary cells, in that order. Every chain has the same depth. A single test-mode input moves the boundary cells, both buffers and the functional output multiplexer into test mode together. In normal mode the core's inputs and outputs pass straight through, and the only element added on the output path is one multiplexer.

Top module: `scan_pkt_wrapper`

## Requirements
- R1: With `test_mode_i` low, `core_pi_o` equals `func_pi_i`, `func_po_o` equals `core_po_i`, and `wr_ready_o`, `scan_en_o`, `busy_o` and `resp_valid_o` all stay low.
- R2: With `test_mode_i` high, `core_pi_o` shows the input boundary cells and `func_po_o` shows the output boundary cells. Outside stage 2 the output cells load `core_po_i` on every clock. Input cells reset to zero.
- R3: In stage 1 a word is taken on each clock with `wr_valid_i` and `wr_ready_o` both high, and word i of a packet is stored at buffer position i. The packet length is `pkt_words_i`, with 0 treated as 1 and values above DEPTH treated as DEPTH. `buf_full_o` rises after the last word is written, and `wr_ready_o` is low while `buf_full_o` is high.
- R4: Stage 2 begins on the clock after `buf_full_o` is seen. It lasts S*(D+1) cycles, where S = words*BUS_W/NUM_CH and D = `div_ratio_i`. `scan_en_o` pulses once every D+1 cycles of stage 2, and the first pulse comes in the (D+1)-th cycle.
- R5: Slice s of a packet is bits [s*NUM_CH +: NUM_CH] of the concatenated words, with word 0 in the low bits. Bit k of the slice enters chain k, and slice 0 is shifted first.
- R6: Wrapper chain k runs through input cells k*L..k*L+L-1, entered at the lowest, where L = BUS_W/NUM_CH. It continues through core chain k (`core_si_o[k]` in, `core_so_i[k]` out) and then through output cells numbered the same way. Every chain has the same depth.
- R7: On shift s, the last bit of each chain is stored as response bit s*NUM_CH+k. `resp_valid_o` rises after the final shift.
- R8: While `resp_valid_o` is high, `rd_data_o` holds response word r, starting with r = 0. Each clock with `rd_req_i` high moves on to the next word. After the last word the wrapper returns to stage 1 with `wr_ready_o` high.
- R9: `wr_ready_o` stays low during stage 2 and while a response is pending. A write offered then is ignored. A read request before the response is complete is ignored.
- R10: Dropping `test_mode_i` aborts any packet in progress. Once test mode returns, a full packet must be written again before stage 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | Test/normal select |
| div_ratio_i | input | DIV_W | Scan divider; one shift every value+1 cycles |
| pkt_words_i | input | WC_W | Packet length in words |
| wr_valid_i | input | 1 | Stimulus word offered |
| wr_data_i | input | BUS_W | Stimulus word |
| wr_ready_o | output | 1 | Stimulus word can be taken |
| buf_full_o | output | 1 | Packet fully loaded |
| rd_req_i | input | 1 | Response word taken by master |
| rd_data_o | output | BUS_W | Current response word |
| resp_valid_o | output | 1 | Response ready for reading |
| busy_o | output | 1 | Stage 2 in progress |
| scan_en_o | output | 1 | Core chain shift enable |
| core_si_o | output | NUM_CH | Scan inputs of core chains |
| core_so_i | input | NUM_CH | Scan outputs of core chains |
| func_pi_i | input | BUS_W | Functional values for core inputs |
| core_pi_o | output | BUS_W | Core primary inputs |
| core_po_i | input | BUS_W | Core primary outputs |
| func_po_o | output | BUS_W | Functional outputs toward the system |

## Verification
The hardest state to reach from the ports is a packet whose response depends on history. Its response carries bits left in the core chains by the previous packet and output-cell values captured from the previous input-cell contents. Packets are therefore run back to back with random lengths (including the clamped values 0 and 7), random divider ratios and random read stalls. A bench model follows every wrapper cell and core bit across packets. Junk writes are held during stage 2, and reads are requested during stage 1. One packet is aborted by leaving test mode partway through loading.

// File: rtl/spw_pkg.sv
package spw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_RESP  = 2'd2
  } spw_state_e;
endpackage

// File: rtl/spw_ctrl.sv
module spw_ctrl
  import spw_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 4,
  parameter int DIV_W  = 3,
  localparam int WC_W    = $clog2(DEPTH + 1),
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SL_PER_W = BUS_W / NUM_CH,
  localparam int MAX_SL  = DEPTH * SL_PER_W,
  localparam int SLI_W   = (MAX_SL > 1) ? $clog2(MAX_SL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             test_mode_i,
  input  logic [DIV_W-1:0] div_ratio_i,
  input  logic [WC_W-1:0]  pkt_words_i,
  input  logic             wr_valid_i,
  input  logic             rd_req_i,
  output logic             wr_ready_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             shift_o,
  output logic [SLI_W-1:0] sl_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             busy_o,
  output logic             resp_valid_o,
  output logic             buf_full_o
);

  spw_state_e       state_q;
  logic [WC_W-1:0]  wr_cnt_q, rd_cnt_q, plen_q, eff_len;
  logic [SLI_W-1:0] sl_cnt_q;
  logic [DIV_W-1:0] div_cnt_q;
  logic first_word, wr_fire, pkt_loaded, tick, last_slice, last_read, rd_fire;

  function automatic logic [WC_W-1:0] clamp_len(input logic [WC_W-1:0] v);
    if (v == '0) return WC_W'(1);
    if (v > WC_W'(DEPTH)) return WC_W'(DEPTH);
    return v;
  endfunction

  assign first_word = (state_q == ST_IDLE) && (wr_cnt_q == '0);
  assign eff_len    = first_word ? clamp_len(pkt_words_i) : plen_q;
  assign wr_ready_o = test_mode_i && (state_q == ST_IDLE) && (wr_cnt_q < eff_len);
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign pkt_loaded = (state_q == ST_IDLE) && (wr_cnt_q == eff_len);
  assign tick       = test_mode_i && (state_q == ST_SHIFT) && (div_cnt_q == div_ratio_i);
  assign last_slice = (int'(sl_cnt_q) == int'(plen_q) * SL_PER_W - 1);
  assign last_read  = (rd_cnt_q == plen_q - WC_W'(1));
  assign rd_fire    = test_mode_i && (state_q == ST_RESP) && rd_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      wr_cnt_q  <= '0;
      rd_cnt_q  <= '0;
      plen_q    <= WC_W'(1);
      sl_cnt_q  <= '0;
      div_cnt_q <= '0;
    end else if (!test_mode_i) begin
      // leaving test mode discards any packet in flight
      state_q   <= ST_IDLE;
      wr_cnt_q  <= '0;
      rd_cnt_q  <= '0;
      sl_cnt_q  <= '0;
      div_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (first_word) plen_q <= clamp_len(pkt_words_i);
          if (wr_fire) wr_cnt_q <= wr_cnt_q + WC_W'(1);
          if (pkt_loaded) begin
            state_q   <= ST_SHIFT;
            sl_cnt_q  <= '0;
            div_cnt_q <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            div_cnt_q <= '0;
            sl_cnt_q  <= sl_cnt_q + SLI_W'(1);
            if (last_slice) begin
              state_q  <= ST_RESP;
              rd_cnt_q <= '0;
            end
          end else begin
            div_cnt_q <= div_cnt_q + DIV_W'(1);
          end
        end
        ST_RESP: begin
          if (rd_fire) begin
            rd_cnt_q <= rd_cnt_q + WC_W'(1);
            if (last_read) begin
              state_q  <= ST_IDLE;
              wr_cnt_q <= '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en_o      = wr_fire;
  assign wr_idx_o     = wr_cnt_q[IDX_W-1:0];
  assign shift_o      = tick;
  assign sl_idx_o     = sl_cnt_q;
  assign rd_idx_o     = rd_cnt_q[IDX_W-1:0];
  assign busy_o       = (state_q == ST_SHIFT);
  assign resp_valid_o = (state_q == ST_RESP);
  assign buf_full_o   = pkt_loaded || (state_q == ST_SHIFT);

endmodule

// File: rtl/spw_in_buf.sv
module spw_in_buf #(
  parameter int BUS_W  = 8,
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 4,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int MAX_SL = DEPTH * (BUS_W / NUM_CH),
  localparam int SLI_W  = (MAX_SL > 1) ? $clog2(MAX_SL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic [SLI_W-1:0]  sl_idx_i,
  output logic [NUM_CH-1:0] slice_o
);

  logic [DEPTH*BUS_W-1:0] flat;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [BUS_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (wr_en_i && (int'(wr_idx_i) == w)) word_q <= wr_data_i;
    end
    assign flat[w*BUS_W +: BUS_W] = word_q;
  end

  // parallel-to-serial: one NUM_CH-bit slice per scan shift
  assign slice_o = flat[int'(sl_idx_i)*NUM_CH +: NUM_CH];

endmodule

// File: rtl/spw_out_buf.sv
module spw_out_buf #(
  parameter int BUS_W  = 8,
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 4,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int MAX_SL = DEPTH * (BUS_W / NUM_CH),
  localparam int SLI_W  = (MAX_SL > 1) ? $clog2(MAX_SL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [SLI_W-1:0]  sl_idx_i,
  input  logic [NUM_CH-1:0] chain_out_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [BUS_W-1:0]  rd_data_o
);

  logic [DEPTH*BUS_W-1:0] flat;

  for (genvar s = 0; s < MAX_SL; s++) begin : g_slice
    logic [NUM_CH-1:0] resp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) resp_q <= '0;
      else if (shift_i && (int'(sl_idx_i) == s)) resp_q <= chain_out_i;
    end
    assign flat[s*NUM_CH +: NUM_CH] = resp_q;
  end

  assign rd_data_o = flat[int'(rd_idx_i)*BUS_W +: BUS_W];

endmodule

// File: rtl/spw_bnd.sv
module spw_bnd #(
  parameter int BUS_W  = 8,
  parameter int NUM_CH = 4,
  localparam int L = BUS_W / NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_mode_i,
  input  logic              shift_i,
  input  logic              capture_i,
  input  logic [NUM_CH-1:0] si_i,
  input  logic [BUS_W-1:0]  func_pi_i,
  output logic [BUS_W-1:0]  core_pi_o,
  output logic [NUM_CH-1:0] core_si_o,
  input  logic [NUM_CH-1:0] core_so_i,
  input  logic [BUS_W-1:0]  core_po_i,
  output logic [BUS_W-1:0]  func_po_o,
  output logic [NUM_CH-1:0] chain_out_o
);

  logic [BUS_W-1:0] pi_cells, po_cells;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chain
    logic [L-1:0] ib_q, ob_q;
    if (L > 1) begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ib_q <= '0;
          ob_q <= '0;
        end else if (shift_i) begin
          ib_q <= {ib_q[L-2:0], si_i[k]};
          ob_q <= {ob_q[L-2:0], core_so_i[k]};
        end else if (capture_i) begin
          ob_q <= core_po_i[k*L +: L];
        end
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ib_q <= '0;
          ob_q <= '0;
        end else if (shift_i) begin
          ib_q <= si_i[k];
          ob_q <= core_so_i[k];
        end else if (capture_i) begin
          ob_q <= core_po_i[k*L +: L];
        end
      end
    end
    assign pi_cells[k*L +: L] = ib_q;
    assign po_cells[k*L +: L] = ob_q;
    assign core_si_o[k]       = ib_q[L-1];
    assign chain_out_o[k]     = ob_q[L-1];
  end

  assign core_pi_o = test_mode_i ? pi_cells : func_pi_i;
  assign func_po_o = test_mode_i ? po_cells : core_po_i;

endmodule

// File: rtl/scan_pkt_wrapper.sv
module scan_pkt_wrapper #(
  parameter int BUS_W  = 8,
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 4,
  parameter int DIV_W  = 3,
  localparam int WC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_mode_i,
  input  logic [DIV_W-1:0]  div_ratio_i,
  input  logic [WC_W-1:0]   pkt_words_i,
  input  logic              wr_valid_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic              wr_ready_o,
  output logic              buf_full_o,
  input  logic              rd_req_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic              resp_valid_o,
  output logic              busy_o,
  output logic              scan_en_o,
  output logic [NUM_CH-1:0] core_si_o,
  input  logic [NUM_CH-1:0] core_so_i,
  input  logic [BUS_W-1:0]  func_pi_i,
  output logic [BUS_W-1:0]  core_pi_o,
  input  logic [BUS_W-1:0]  core_po_i,
  output logic [BUS_W-1:0]  func_po_o
);

  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int MAX_SL = DEPTH * (BUS_W / NUM_CH);
  localparam int SLI_W  = (MAX_SL > 1) ? $clog2(MAX_SL) : 1;

  logic              wr_en, shift;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [SLI_W-1:0]  sl_idx;
  logic [NUM_CH-1:0] slice, chain_out;

  spw_ctrl #(.BUS_W(BUS_W), .NUM_CH(NUM_CH), .DEPTH(DEPTH), .DIV_W(DIV_W)) u_ctrl (
    .clk_i, .rst_ni, .test_mode_i, .div_ratio_i, .pkt_words_i, .wr_valid_i, .rd_req_i,
    .wr_ready_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .shift_o(shift), .sl_idx_o(sl_idx),
    .rd_idx_o(rd_idx), .busy_o, .resp_valid_o, .buf_full_o
  );

  spw_in_buf #(.BUS_W(BUS_W), .NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_ibuf (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i,
    .sl_idx_i(sl_idx), .slice_o(slice)
  );

  spw_bnd #(.BUS_W(BUS_W), .NUM_CH(NUM_CH)) u_bnd (
    .clk_i, .rst_ni, .test_mode_i, .shift_i(shift),
    .capture_i(test_mode_i && !busy_o), .si_i(slice),
    .func_pi_i, .core_pi_o, .core_si_o, .core_so_i, .core_po_i, .func_po_o,
    .chain_out_o(chain_out)
  );

  spw_out_buf #(.BUS_W(BUS_W), .NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_obuf (
    .clk_i, .rst_ni, .shift_i(shift), .sl_idx_i(sl_idx), .chain_out_i(chain_out),
    .rd_idx_i(rd_idx), .rd_data_o
  );

  assign scan_en_o = shift;

endmodule

// File: rtl/spw_checker.sv
module spw_checker #(
  parameter int BUS_W = 8,
  parameter int DIV_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             test_mode_i,
  input logic [DIV_W-1:0] div_ratio_i,
  input logic             wr_ready_o,
  input logic             buf_full_o,
  input logic             rd_req_i,
  input logic [BUS_W-1:0] rd_data_o,
  input logic             resp_valid_o,
  input logic             busy_o,
  input logic             scan_en_o
);

  a_r4_shift_in_stage2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o |-> busy_o);

  a_r4_shift_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_o && div_ratio_i != '0) |=> !scan_en_o);

  a_r3_full_before_stage2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(buf_full_o));

  a_r9_single_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_ready_o, busy_o, resp_valid_o}));

  a_r9_no_write_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full_o |-> !wr_ready_o);

  a_r7_resp_after_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resp_valid_o) |-> $past(busy_o));

  a_r8_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !rd_req_i) |=> $stable(rd_data_o));

  a_r10_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode_i |=> (!busy_o && !resp_valid_o && !buf_full_o));

  a_r1_normal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode_i |-> (!scan_en_o && !wr_ready_o));

endmodule

bind scan_pkt_wrapper spw_checker #(.BUS_W(BUS_W), .DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .test_mode_i(test_mode_i), .div_ratio_i(div_ratio_i),
  .wr_ready_o(wr_ready_o), .buf_full_o(buf_full_o), .rd_req_i(rd_req_i),
  .rd_data_o(rd_data_o), .resp_valid_o(resp_valid_o), .busy_o(busy_o),
  .scan_en_o(scan_en_o)
);

// File: tb/scan_pkt_wrapper_tb_top.sv
`timescale 1ns/1ps
module scan_pkt_wrapper_tb_top;
  localparam int BUS_W = 8, NUM_CH = 4, DEPTH = 4, DIV_W = 3;
  localparam int WC_W = $clog2(DEPTH + 1);
  localparam int L = BUS_W / NUM_CH;
  localparam int CORE_LEN = 4;

  logic clk, rst_n, test_mode, wr_valid, wr_ready, buf_full, rd_req, resp_valid, busy, scan_en;
  logic [DIV_W-1:0]  div_ratio;
  logic [WC_W-1:0]   pkt_words;
  logic [BUS_W-1:0]  wr_data, rd_data, func_pi, core_pi, core_po, func_po;
  logic [NUM_CH-1:0] core_si, core_so;

  int checks = 0, errors = 0;
  bit done = 0;

  scan_pkt_wrapper dut_i (
    .clk_i(clk), .rst_ni(rst_n), .test_mode_i(test_mode), .div_ratio_i(div_ratio),
    .pkt_words_i(pkt_words), .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .buf_full_o(buf_full), .rd_req_i(rd_req), .rd_data_o(rd_data), .resp_valid_o(resp_valid),
    .busy_o(busy), .scan_en_o(scan_en), .core_si_o(core_si), .core_so_i(core_so),
    .func_pi_i(func_pi), .core_pi_o(core_pi), .core_po_i(core_po), .func_po_o(func_po)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [BUS_W-1:0] core_fn(input logic [BUS_W-1:0] pi);
    return {pi[BUS_W-2:0], pi[BUS_W-1]} ^ BUS_W'(8'hA5);
  endfunction

  // core under test: internal chains and combinational output function
  logic [CORE_LEN-1:0] core_q [NUM_CH];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_CH; k++) core_q[k] <= '0;
    end else if (scan_en) begin
      for (int k = 0; k < NUM_CH; k++) core_q[k] <= {core_q[k][CORE_LEN-2:0], core_si[k]};
    end
  end
  always_comb for (int k = 0; k < NUM_CH; k++) core_so[k] = core_q[k][CORE_LEN-1];
  assign core_po = core_fn(core_pi);

  // bench-side mirror of every wrapper chain bit
  logic [L-1:0]        m_ib [NUM_CH];
  logic [L-1:0]        m_ob [NUM_CH];
  logic [CORE_LEN-1:0] m_core [NUM_CH];

  function automatic logic [BUS_W-1:0] model_pi();
    logic [BUS_W-1:0] p;
    for (int k = 0; k < NUM_CH; k++) p[k*L +: L] = m_ib[k];
    return p;
  endfunction

  // R5 R6: slice ordering and chain composition are encoded here
  task automatic predict(input int n, input logic [DEPTH*BUS_W-1:0] pkt,
                         output logic [DEPTH*BUS_W-1:0] resp);
    logic [BUS_W-1:0] po;
    resp = '0;
    po = core_fn(model_pi());
    for (int k = 0; k < NUM_CH; k++) m_ob[k] = po[k*L +: L];
    for (int s = 0; s < n * L; s++) begin
      for (int k = 0; k < NUM_CH; k++) begin
        resp[s*NUM_CH+k] = m_ob[k][L-1];
        m_ob[k]   = {m_ob[k][L-2:0], m_core[k][CORE_LEN-1]};
        m_core[k] = {m_core[k][CORE_LEN-2:0], m_ib[k][L-1]};
        m_ib[k]   = {m_ib[k][L-2:0], pkt[s*NUM_CH+k]};
      end
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_packet(input int nreq, input int div);
    int n, busy_c, en_c;
    bit bad_en, bad_rdy;
    logic [DEPTH*BUS_W-1:0] pkt, resp;
    logic [BUS_W-1:0] pi;
    n = (nreq == 0) ? 1 : ((nreq > DEPTH) ? DEPTH : nreq);
    pkt = '0;
    for (int w = 0; w < n; w++) pkt[w*BUS_W +: BUS_W] = BUS_W'($urandom);
    predict(n, pkt, resp);
    @(negedge clk);
    pkt_words = WC_W'(nreq);
    div_ratio = DIV_W'(div);
    rd_req = 1'b1;
    chk(!resp_valid, "R9", "read accepted before response", resp_valid, 0);
    for (int w = 0; w < n; w++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = pkt[w*BUS_W +: BUS_W];
      chk(!buf_full, "R3", "full before last word", buf_full, 0);
      while (!wr_ready) @(negedge clk);
    end
    @(negedge clk);
    rd_req  = 1'b0;
    wr_data = BUS_W'($urandom);
    chk(buf_full && !wr_ready, "R3", "full/ready after last word", {buf_full, wr_ready}, 2'b10);
    busy_c = 0; en_c = 0; bad_en = 0; bad_rdy = 0;
    while (!resp_valid) begin
      @(negedge clk);
      if (wr_ready) bad_rdy = 1;
      if (busy) begin
        busy_c++;
        if (scan_en && (busy_c % (div + 1)) != 0) bad_en = 1;
      end
      if (scan_en) en_c++;
    end
    chk(busy_c == n * L * (div + 1), "R4", "stage 2 length", busy_c, n * L * (div + 1));
    chk(en_c == n * L, "R4", "shift count", en_c, n * L);
    chk(!bad_en, "R4", "shift pulse position", bad_en, 0);
    chk(!bad_rdy, "R9", "write ready during stage 2", bad_rdy, 0);
    wr_valid = 1'b0;
    for (int w = 0; w < n; w++) begin
      if ($urandom % 3 == 0) begin
        rd_req = 1'b0;
        @(negedge clk);
      end
      rd_req = 1'b1;
      chk(resp_valid && rd_data == resp[w*BUS_W +: BUS_W], "R7", $sformatf("response word %0d", w),
          {resp_valid, rd_data}, {1'b1, resp[w*BUS_W +: BUS_W]});
      @(negedge clk);
    end
    rd_req = 1'b0;
    chk(!resp_valid && wr_ready, "R8", "back to loading after reads", {resp_valid, wr_ready}, 2'b01);
    pi = model_pi();
    chk(core_pi == pi, "R2", "input cells on core inputs", core_pi, pi);
    chk(func_po == core_fn(pi), "R2", "output cells captured", func_po, core_fn(pi));
  endtask

  task automatic normal_phase();
    @(negedge clk);
    test_mode = 1'b0;
    for (int i = 0; i < 4; i++) begin
      func_pi = BUS_W'($urandom);
      @(negedge clk);
      chk(core_pi == func_pi, "R1", "input pass-through", core_pi, func_pi);
      chk(func_po == core_po, "R1", "output pass-through", func_po, core_po);
      chk(!wr_ready && !scan_en && !busy && !resp_valid, "R1", "quiet in normal mode",
          {wr_ready, scan_en, busy, resp_valid}, 0);
    end
    test_mode = 1'b1;
    @(negedge clk);
  endtask

  task automatic abort_phase();
    @(negedge clk);
    pkt_words = WC_W'(3);
    wr_valid = 1'b1;
    wr_data = BUS_W'($urandom);
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_data = BUS_W'($urandom);
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    test_mode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    test_mode = 1'b1;
    @(negedge clk);
    chk(!buf_full && wr_ready, "R10", "partial packet discarded", {buf_full, wr_ready}, 2'b01);
    run_packet(3, 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; test_mode = 0; div_ratio = '0; pkt_words = '0; wr_valid = 0;
    wr_data = '0; rd_req = 0; func_pi = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      m_ib[k] = '0; m_ob[k] = '0; m_core[k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!wr_ready && !busy && !resp_valid && !buf_full, "R1", "reset state in normal mode",
        {wr_ready, busy, resp_valid, buf_full}, 0);
    test_mode = 1'b1;
    pkt_words = WC_W'(1);
    @(negedge clk);
    chk(wr_ready && !buf_full && !resp_valid, "R3", "ready after reset", {wr_ready, buf_full, resp_valid}, 3'b100);
    chk(core_pi == '0, "R2", "input cells reset", core_pi, 0);
    chk(func_po == core_fn('0), "R2", "output cells capture", func_po, core_fn('0));
    run_packet(1, 0);
    run_packet(4, 0);
    run_packet(0, 2);
    run_packet(7, 1);
    run_packet(2, 3);
    normal_phase();
    abort_phase();
    for (int i = 0; i < 20; i++) run_packet(int'($urandom % 8), int'($urandom % 4));
    normal_phase();
    run_packet(4, 7);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule